// File: doc/BRIEF.md
# SPI Packet FIFO Pair with Status Word

This block sits between an SPI shift engine and the bus side of an SPI controller. It holds two 64-packet queues. The transmit queue is filled from the bus side and drained by the shift engine. The receive queue is filled by the shift engine and drained from the bus side. A 32-bit status word reports the state of both queues:

- how many packets the receive queue holds,
- how many free slots the transmit queue has,
- full and empty flags for each queue,
- sticky overflow and underrun flags for each direction, with a summary error bit.

Software empties a queue by writing a flush request bit. It then polls that bit until the hardware drops it, which happens one cycle after the request.

A second register holds two 2-bit DMA trigger codes. The transmit DMA request stays high while the free space in the transmit queue reaches the trigger level. The receive DMA request stays high while the receive queue's fill level reaches its trigger level.

Both registers share one write/read port with a one-bit address:

- Address 0 selects the status word.
- Address 1 selects the trigger register.

Reads are combinational. Pops are first-word fall-through: the data port shows the head packet before the pop edge.

Top module: `spi_fifo_pair`

## Requirements
- R1: After synchronous reset, both queues are empty and the status word reads 0x00400005: free count 64 in [22:16], empty bits 2 and 0 set, everything else zero. The trigger register reads 0, and with trigger code 0 the transmit DMA request is high.
- R2: Each queue returns packets in push order. Status field [29:23] gives the receive fill count. Field [22:16] gives the transmit free count (64 minus the fill). Both fields update on the clock edge of the push or pop.
- R3: Bit 3 (transmit full) and bit 1 (receive full) are set exactly when that queue holds 64 packets. Bit 2 (transmit empty) and bit 0 (receive empty) are set exactly when that queue holds 0 packets.
- R4: A push to a full queue is dropped, even when a pop happens in the same cycle. The drop sets the sticky overflow flag: bit 7 for transmit, bit 5 for receive.
- R5: A pop from an empty queue returns zero and leaves the count at zero. It sets the sticky underrun flag: bit 6 for transmit, bit 4 for receive.
- R6: Bit 8 reads as the OR of bits 7..4. Writing a 1 to any of bits 7..4 at address 0 clears that flag. If a new error event and a clear land in the same cycle, the flag stays set.
- R7: Writing 1 to bit 15 (receive) or bit 14 (transmit) at address 0 makes that bit read 1 for exactly one cycle. In that cycle the queue ignores pushes and pops and raises no flags. At the next edge the queue becomes empty and the bit reads 0.
- R8: Address 1 holds the receive trigger code in [20:19] and the transmit trigger code in [16:15]. The codes map 0, 1, 2 and 3 to trigger levels of 1, 4, 8 and 16 packets. dma_rx_req is high while the receive fill count is at least the receive level. dma_tx_req is high while the transmit free count is at least the transmit level.
- R9: A write to address 0 does not change the count fields, the full or empty bits, or bits 13..9. Only flush bits 15 and 14 and clear bits 7..4 have an effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 1 | Register select: 0 = status word, 1 = trigger register |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from reg_addr |
| bus_tx_push | input | 1 | Bus side pushes a packet into the transmit queue |
| bus_tx_data | input | 8 | Packet pushed into the transmit queue |
| bus_rx_pop | input | 1 | Bus side pops a packet from the receive queue |
| bus_rx_data | output | 8 | Head of the receive queue, zero when empty |
| eng_tx_pop | input | 1 | Shift engine pops a packet from the transmit queue |
| eng_tx_data | output | 8 | Head of the transmit queue, zero when empty |
| eng_rx_push | input | 1 | Shift engine pushes a packet into the receive queue |
| eng_rx_data | input | 8 | Packet pushed into the receive queue |
| dma_tx_req | output | 1 | Transmit DMA request |
| dma_rx_req | output | 1 | Receive DMA request |

## Verification
A wrong pointer or count becomes visible in the status word on the very next edge. It shows up as a wrong fill or free field, or as a mismatched full or empty bit. A corrupted storage slot stays hidden until that packet reaches the head of its queue, so the bench checks every popped packet against a reference queue.

A flag that fails to stick, or that clears too early, shows only at the next status read. For that reason the status word is compared after every cycle. A flush that lingers or never completes shows as bit 15 or bit 14 staying high for a second cycle.

// File: rtl/spi_fifo_pkg.sv
// Shared constants and helpers for the SPI FIFO pair.
// Assumes the packet queues hold at most 64 entries, so the occupancy fields fit in 7 bits.
package spi_fifo_pkg;

    localparam int STAT_CNT_W = 7;

    // Bit positions in the status word. Software decodes these, so they are fixed.
    localparam int RX_CNT_LSB  = 23;
    localparam int TX_FREE_LSB = 16;
    localparam int RX_FLUSH_B  = 15;
    localparam int TX_FLUSH_B  = 14;
    localparam int ERR_SUM_B   = 8;

    // Bit positions of the trigger codes in the trigger register.
    localparam int RX_TRIG_LSB = 19;
    localparam int TX_TRIG_LSB = 15;

    // Map a 2-bit trigger code to a trigger level in packets.
    function automatic logic [STAT_CNT_W-1:0] trig_level(input logic [1:0] code);
        case (code)
            2'd0:    trig_level = 7'd1;
            2'd1:    trig_level = 7'd4;
            2'd2:    trig_level = 7'd8;
            default: trig_level = 7'd16;
        endcase
    endfunction

endpackage

// File: rtl/pkt_queue.sv
// Circular packet queue with first-word fall-through read and a synchronous flush.
// A push while full and a pop while empty are refused and reported as one-cycle
// events. While flush is high, all operations are ignored and the queue is emptied
// at the edge.
// Assumes DEPTH >= 2.
module pkt_queue #(
    parameter int DW    = 8,
    parameter int DEPTH = 64,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          push,
    input  logic [DW-1:0] push_data,
    input  logic          pop,
    output logic [DW-1:0] head_data,
    output logic [CW-1:0] fill,
    output logic          full,
    output logic          empty,
    output logic          ovf_evt,
    output logic          unr_evt
);

    logic [DW-1:0] store [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic          do_push, do_pop;

    assign full    = (fill == CW'(DEPTH));
    assign empty   = (fill == '0);
    assign do_push = push && !full && !flush;
    assign do_pop  = pop && !empty && !flush;
    assign ovf_evt = push && full && !flush;
    assign unr_evt = pop && empty && !flush;

    // Head packet, forced to zero when the queue is empty.
    assign head_data = empty ? '0 : store[rd_ptr];

    // Write an accepted packet into storage.
    always_ff @(posedge clk) begin
        if (do_push) store[wr_ptr] <= push_data;
    end

    // Advance the pointers and the fill count; flush resets all three.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            fill   <= '0;
        end else begin
            if (do_push) wr_ptr <= (wr_ptr == AW'(DEPTH-1)) ? '0 : wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= (rd_ptr == AW'(DEPTH-1)) ? '0 : rd_ptr + 1'b1;
            case ({do_push, do_pop})
                2'b10:   fill <= fill + 1'b1;
                2'b01:   fill <= fill - 1'b1;
                default: fill <= fill;
            endcase
        end
    end

endmodule

// File: rtl/sticky_flags.sv
// Bank of sticky error flags. A flag is cleared by its clear bit and set by its
// event. When both happen in the same cycle, the set wins.
module sticky_flags #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_evt,
    input  logic [N-1:0] clr,
    output logic [N-1:0] flags
);

    // Hold each flag until it is cleared; a new event overrides a clear.
    always_ff @(posedge clk) begin
        if (!rst_n) flags <= '0;
        else        flags <= (flags & ~clr) | set_evt;
    end

endmodule

// File: rtl/dma_trigger.sv
// Raise a DMA request while a level reaches the packet count set by a trigger code.
// Purely combinational.
module dma_trigger
    import spi_fifo_pkg::*;
(
    input  logic [STAT_CNT_W-1:0] level,
    input  logic [1:0]            code,
    output logic                  req
);

    // Compare the level against the decoded trigger level.
    always_comb req = (level >= trig_level(code));

endmodule

// File: rtl/spi_fifo_pair.sv
// Transmit and receive packet queues for an SPI controller, with a 32-bit status
// word, self-clearing flush requests, sticky error flags and DMA trigger requests.
// Address 0 selects the status word and address 1 selects the trigger register.
// Assumes DEPTH <= 64, so the occupancy fields fit in 7 bits.
module spi_fifo_pair
    import spi_fifo_pkg::*;
#(
    parameter int DW    = 8,
    parameter int DEPTH = 64
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_wr_en,
    input  logic          reg_addr,
    input  logic [31:0]   reg_wdata,
    output logic [31:0]   reg_rdata,
    input  logic          bus_tx_push,
    input  logic [DW-1:0] bus_tx_data,
    input  logic          bus_rx_pop,
    output logic [DW-1:0] bus_rx_data,
    input  logic          eng_tx_pop,
    output logic [DW-1:0] eng_tx_data,
    input  logic          eng_rx_push,
    input  logic [DW-1:0] eng_rx_data,
    output logic          dma_tx_req,
    output logic          dma_rx_req
);

    localparam int CW = $clog2(DEPTH) + 1;

    logic          stat_wr, ctl_wr;
    logic          rx_flush_pend, tx_flush_pend;
    logic [CW-1:0] tx_fill, rx_fill;
    logic          tx_full, tx_empty, rx_full, rx_empty;
    logic          tx_ovf, tx_unr, rx_ovf, rx_unr;
    logic [3:0]    err_flags;
    logic [1:0]    rx_trig_code, tx_trig_code;
    logic [STAT_CNT_W-1:0] rx_cnt_f, tx_free_f;
    logic [31:0]   status_word, ctl_word;

    assign stat_wr = reg_wr_en && !reg_addr;
    assign ctl_wr  = reg_wr_en && reg_addr;

    pkt_queue #(.DW(DW), .DEPTH(DEPTH)) u_txq (
        .clk(clk), .rst_n(rst_n), .flush(tx_flush_pend),
        .push(bus_tx_push), .push_data(bus_tx_data),
        .pop(eng_tx_pop), .head_data(eng_tx_data),
        .fill(tx_fill), .full(tx_full), .empty(tx_empty),
        .ovf_evt(tx_ovf), .unr_evt(tx_unr)
    );

    pkt_queue #(.DW(DW), .DEPTH(DEPTH)) u_rxq (
        .clk(clk), .rst_n(rst_n), .flush(rx_flush_pend),
        .push(eng_rx_push), .push_data(eng_rx_data),
        .pop(bus_rx_pop), .head_data(bus_rx_data),
        .fill(rx_fill), .full(rx_full), .empty(rx_empty),
        .ovf_evt(rx_ovf), .unr_evt(rx_unr)
    );

    // Flag order {tx_ovf, tx_unr, rx_ovf, rx_unr} lines up with status bits 7..4.
    sticky_flags #(.N(4)) u_err (
        .clk(clk), .rst_n(rst_n),
        .set_evt({tx_ovf, tx_unr, rx_ovf, rx_unr}),
        .clr(stat_wr ? reg_wdata[7:4] : 4'b0),
        .flags(err_flags)
    );

    // Hold a flush request for one cycle, then drop it as the queue empties.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_flush_pend <= 1'b0;
            tx_flush_pend <= 1'b0;
        end else begin
            rx_flush_pend <= !rx_flush_pend && stat_wr && reg_wdata[RX_FLUSH_B];
            tx_flush_pend <= !tx_flush_pend && stat_wr && reg_wdata[TX_FLUSH_B];
        end
    end

    // Trigger register: one 2-bit code per direction.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_trig_code <= 2'd0;
            tx_trig_code <= 2'd0;
        end else if (ctl_wr) begin
            rx_trig_code <= reg_wdata[RX_TRIG_LSB +: 2];
            tx_trig_code <= reg_wdata[TX_TRIG_LSB +: 2];
        end
    end

    assign rx_cnt_f  = STAT_CNT_W'(rx_fill);
    assign tx_free_f = STAT_CNT_W'(CW'(DEPTH) - tx_fill);

    dma_trigger u_tx_trig (.level(tx_free_f), .code(tx_trig_code), .req(dma_tx_req));
    dma_trigger u_rx_trig (.level(rx_cnt_f),  .code(rx_trig_code), .req(dma_rx_req));

    // Assemble the status word and the trigger register image.
    always_comb begin
        status_word = '0;
        status_word[RX_CNT_LSB  +: STAT_CNT_W] = rx_cnt_f;
        status_word[TX_FREE_LSB +: STAT_CNT_W] = tx_free_f;
        status_word[RX_FLUSH_B] = rx_flush_pend;
        status_word[TX_FLUSH_B] = tx_flush_pend;
        status_word[ERR_SUM_B]  = |err_flags;
        status_word[7:4]        = err_flags;
        status_word[3:0]        = {tx_full, tx_empty, rx_full, rx_empty};
        ctl_word = '0;
        ctl_word[RX_TRIG_LSB +: 2] = rx_trig_code;
        ctl_word[TX_TRIG_LSB +: 2] = tx_trig_code;
    end

    // Read mux on the register address.
    assign reg_rdata = reg_addr ? ctl_word : status_word;

endmodule

// File: rtl/spi_fifo_pair_chk.sv
// Temporal checks on the SPI FIFO pair, attached through bind.
// Observes the top-level ports and the internal status word.
module spi_fifo_pair_chk #(
    parameter int DEPTH = 64
) (
    input logic        clk,
    input logic        rst_n,
    input logic        reg_wr_en,
    input logic        reg_addr,
    input logic        bus_tx_push,
    input logic        bus_rx_pop,
    input logic [31:0] status,
    input logic        dma_rx_req
);

    // R3
    full_empty_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(status[3] && status[2]) && !(status[1] && status[0]));

    // R2
    rx_fill_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        status[29:23] <= 7'(DEPTH));

    // R4
    tx_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_tx_push && status[3] && !status[14] |=> status[7]);

    // R5
    rx_underrun_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rx_pop && status[0] && !status[15] |=> status[4]);

    // R6
    err_clear_by_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(status[8]) |-> $past(reg_wr_en && !reg_addr));

    // R7
    rx_flush_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        status[15] |=> !status[15] && status[29:23] == 7'd0);

    // R8
    rx_req_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dma_rx_req |-> status[29:23] != 7'd0);

endmodule

bind spi_fifo_pair spi_fifo_pair_chk #(.DEPTH(DEPTH)) u_chk (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
    .bus_tx_push(bus_tx_push), .bus_rx_pop(bus_rx_pop),
    .status(status_word), .dma_rx_req(dma_rx_req)
);

// File: tb/sim_spi_fifo_pair.sv
`timescale 1ns/1ps
module sim_spi_fifo_pair;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_en = 1'b0, reg_addr = 1'b0;
    logic [31:0] reg_wdata = '0, reg_rdata;
    logic        bus_tx_push = 1'b0, bus_rx_pop = 1'b0, eng_tx_pop = 1'b0, eng_rx_push = 1'b0;
    logic [7:0]  bus_tx_data = '0, eng_rx_data = '0, bus_rx_data, eng_tx_data;
    logic        dma_tx_req, dma_rx_req;

    int total = 0, bad = 0;

    // Reference model state.
    logic [7:0] txq[$];
    logic [7:0] rxq[$];
    logic [3:0] m_flags = '0;
    logic       m_rxp = 1'b0, m_txp = 1'b0;
    logic [1:0] m_rtrig = '0, m_ttrig = '0;

    always #5 clk = ~clk;

    spi_fifo_pair u0 (.*);

    function automatic int lvl(input logic [1:0] c);
        return (c == 0) ? 1 : (c == 1) ? 4 : (c == 2) ? 8 : 16;
    endfunction

    function automatic logic [31:0] exp_status();
        logic [31:0] s = '0;
        s[29:23] = 7'(rxq.size());
        s[22:16] = 7'(64 - txq.size());
        s[15] = m_rxp;
        s[14] = m_txp;
        s[8] = |m_flags;
        s[7:4] = m_flags;
        s[3] = (txq.size() == 64);
        s[2] = (txq.size() == 0);
        s[1] = (rxq.size() == 64);
        s[0] = (rxq.size() == 0);
        return s;
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One clock: drive the inputs, check the pop data, step the model, then check status and requests.
    task automatic cycle(input string tag, input bit tpush, input logic [7:0] tdata, input bit tpop,
                         input bit rpush, input logic [7:0] rdata, input bit rpop,
                         input bit wr, input bit addr, input logic [31:0] wdata);
        logic [3:0] set_v, clr_v;
        bit tfull, tempty, rfull, rempty;
        bus_tx_push = tpush; bus_tx_data = tdata; eng_tx_pop = tpop;
        eng_rx_push = rpush; eng_rx_data = rdata; bus_rx_pop = rpop;
        reg_wr_en = wr; reg_addr = addr; reg_wdata = wdata;
        #1;
        if (tpop && !m_txp)
            check(txq.size() == 0 ? "R5 tx pop data" : "R2 tx pop data", 32'(eng_tx_data),
                  txq.size() == 0 ? 32'd0 : 32'(txq[0]));
        if (rpop && !m_rxp)
            check(rxq.size() == 0 ? "R5 rx pop data" : "R2 rx pop data", 32'(bus_rx_data),
                  rxq.size() == 0 ? 32'd0 : 32'(rxq[0]));
        set_v = '0;
        tfull = (txq.size() == 64); tempty = (txq.size() == 0);
        rfull = (rxq.size() == 64); rempty = (rxq.size() == 0);
        if (m_txp) txq.delete();
        else begin
            if (tpop) begin if (tempty) set_v[2] = 1'b1; else void'(txq.pop_front()); end
            if (tpush) begin if (tfull) set_v[3] = 1'b1; else txq.push_back(tdata); end
        end
        if (m_rxp) rxq.delete();
        else begin
            if (rpop) begin if (rempty) set_v[0] = 1'b1; else void'(rxq.pop_front()); end
            if (rpush) begin if (rfull) set_v[1] = 1'b1; else rxq.push_back(rdata); end
        end
        clr_v = (wr && !addr) ? wdata[7:4] : 4'b0;
        m_flags = (m_flags & ~clr_v) | set_v;
        m_rxp = !m_rxp && wr && !addr && wdata[15];
        m_txp = !m_txp && wr && !addr && wdata[14];
        if (wr && addr) begin m_rtrig = wdata[20:19]; m_ttrig = wdata[16:15]; end
        @(posedge clk);
        #1;
        bus_tx_push = 0; eng_tx_pop = 0; eng_rx_push = 0; bus_rx_pop = 0;
        reg_wr_en = 0; reg_addr = 0;
        #1;
        check(tag, reg_rdata, exp_status());
        check("R8 tx req", 32'(dma_tx_req), 32'((64 - txq.size()) >= lvl(m_ttrig)));
        check("R8 rx req", 32'(dma_rx_req), 32'(rxq.size() >= lvl(m_rtrig)));
    endtask

    task automatic idle(input string tag);
        cycle(tag, 0, 8'h0, 0, 0, 8'h0, 0, 0, 0, 32'h0);
    endtask

    initial begin
        #2_000_000;
        bad++; total++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h5A17));
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        #1;
        // R1 reset state
        check("R1 status after reset", reg_rdata, 32'h0040_0005);
        check("R1 tx req after reset", 32'(dma_tx_req), 32'd1);
        check("R1 rx req after reset", 32'(dma_rx_req), 32'd0);
        reg_addr = 1; #1;
        check("R1 trigger reg after reset", reg_rdata, 32'h0);
        reg_addr = 0;
        // R2 ordering through both queues
        cycle("R2 tx push", 1, 8'hA1, 0, 1, 8'h51, 0, 0, 0, 0);
        cycle("R2 tx push", 1, 8'hA2, 0, 1, 8'h52, 0, 0, 0, 0);
        cycle("R2 pop", 0, 8'h0, 1, 0, 8'h0, 1, 0, 0, 0);
        cycle("R2 pop", 0, 8'h0, 1, 0, 8'h0, 1, 0, 0, 0);
        // R3, R4: fill tx, then overflow, then push and pop together while full
        for (int i = 0; i < 64; i++) cycle("R3 fill tx", 1, 8'(i), 0, 0, 0, 0, 0, 0, 0);
        check("R3 tx full bit", 32'(reg_rdata[3]), 32'd1);
        cycle("R4 tx overflow", 1, 8'hEE, 0, 0, 0, 0, 0, 0, 0);
        check("R4 tx ovf bit", 32'(reg_rdata[7]), 32'd1);
        cycle("R4 push+pop while full", 1, 8'hEF, 1, 0, 0, 0, 0, 0, 0);
        // R5: rx pop from empty
        cycle("R5 rx underrun", 0, 0, 0, 0, 0, 1, 0, 0, 0);
        check("R5 rx unr bit", 32'(reg_rdata[4]), 32'd1);
        // R6: partial clear keeps summary; full clear drops it; set wins over clear
        cycle("R6 clear tx ovf", 0, 0, 0, 0, 0, 0, 1, 0, 32'h80);
        check("R6 err still set", 32'(reg_rdata[8]), 32'd1);
        cycle("R6 clear with new rx unr", 0, 0, 0, 0, 0, 1, 1, 0, 32'hF0);
        check("R6 set wins", 32'(reg_rdata[4]), 32'd1);
        cycle("R6 clear all", 0, 0, 0, 0, 0, 0, 1, 0, 32'hF0);
        check("R6 err cleared", 32'(reg_rdata[8]), 32'd0);
        // R9: writes to read-only bits have no effect
        cycle("R9 junk write", 0, 0, 0, 0, 0, 0, 1, 0, 32'hFFFF_3F0F);
        // R7: flush tx while it holds packets; ops during the pending cycle are ignored
        cycle("R7 tx flush request", 0, 0, 0, 0, 0, 0, 1, 0, 32'h4000);
        check("R7 flush bit high", 32'(reg_rdata[14]), 32'd1);
        cycle("R7 tx flush done", 1, 8'h77, 1, 0, 0, 0, 0, 0, 0);
        check("R7 tx free count", 32'(reg_rdata[22:16]), 32'd64);
        // R8: trigger codes rx=1 (4 packets), tx=2 (8 packets)
        cycle("R8 write triggers", 0, 0, 0, 0, 0, 0, 1, 1, (32'd1 << 19) | (32'd2 << 15));
        reg_addr = 1; #1;
        check("R8 trigger readback", reg_rdata, (32'd1 << 19) | (32'd2 << 15));
        reg_addr = 0; #1;
        for (int i = 0; i < 4; i++) cycle("R8 rx fill", 0, 0, 0, 1, 8'(8'hC0 + i), 0, 0, 0, 0);
        check("R8 rx req at 4", 32'(dma_rx_req), 32'd1);
        cycle("R7 rx flush request", 0, 0, 0, 0, 0, 0, 1, 0, 32'h8000);
        idle("R7 rx flush done");
        // Random traffic with occasional flushes, clears and trigger changes
        for (int n = 0; n < 6000; n++) begin
            int ph = (n / 500) % 3;
            int pu = (ph == 0) ? 80 : (ph == 1) ? 20 : 50;
            bit w = ($urandom_range(99) < 4);
            bit a = $urandom_range(1);
            logic [31:0] wd = $urandom;
            if (!a && $urandom_range(3) != 0) wd[15:14] = 2'b00;
            cycle("R2 random status", $urandom_range(99) < pu, 8'($urandom), $urandom_range(99) >= pu,
                  $urandom_range(99) < pu, 8'($urandom), $urandom_range(99) >= pu, w, a, wd);
        end
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule